// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block selects which exception a processor core should service next. It accepts up to 32 external request lines and two fixed system exceptions, a non-maskable interrupt and a hard fault. Each external line has an enable bit, a pending bit and a priority, all reached through a small word-addressed register port. The controller keeps a stack of the urgency levels of the handlers that are currently running. It raises `preempt` only when the best pending candidate is strictly more urgent than the handler at the top of that stack.

The core answers `preempt` with `entry_ack`. That pulse clears the winner's pending bit and pushes the winner's level onto the stack. When a handler returns, the core pulses `exit_ack`, which pops the stack and restores the level that was interrupted, so handlers nest. Internally, urgency is a rank where a smaller value is more urgent: rank 0 is the non-maskable interrupt, rank 1 is the hard fault, rank 2+p is programmable level p, and rank 6 means no handler is active.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, all enables, pending bits and priorities read as zero, `preempt` is low and `act_rank` is 6 (idle).
- R2: The priority of line n is the byte at bit offset 8*(n mod 4) of register word 3+n/4. Only bits 7:6 of each byte are kept, so a read returns 0x00, 0x40, 0x80 or 0xC0 per byte, with the low six bits zero.
- R3: A rising edge on `irq_in[n]` sets pending bit n. A line held high does not set the bit again after it is cleared. Writing ones to word 1 sets pending bits and writing ones to word 2 clears them. Words 1 and 2 both read back the pending vector, and word 0 holds the enable vector.
- R4: A line whose enable bit is 0 still latches its pending bit but never wins arbitration.
- R5: Among enabled pending lines, the lower priority value wins. On equal value, the lower line number wins. `exc_num` reports 16+n for line n.
- R6: The non-maskable interrupt (exception 2, rank 0) and the hard fault (exception 3, rank 1) are latched on their rising edges, cannot be masked, and beat every programmable line. The non-maskable interrupt beats the hard fault.
- R7: `preempt` is high only when the winner's rank is strictly below `act_rank`. A winner of equal rank waits.
- R8: `entry_ack` while `preempt` is high clears the winner's pending bit and makes the winner's rank the new `act_rank`. `entry_ack` without `preempt` has no effect.
- R9: `exit_ack` pops the stack and restores the previous `act_rank`. An `exit_ack` when the stack is empty leaves `act_rank` at 6.
- R10: When a set (rising edge or word-1 write) and a clear (entry acknowledge or word-2 write) hit the same pending bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | External request lines, rising-edge sensitive |
| nmi_in | input | 1 | Non-maskable interrupt request, rising-edge sensitive |
| fault_in | input | 1 | Hard fault request, rising-edge sensitive |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| entry_ack | input | 1 | Core takes the reported exception |
| exit_ack | input | 1 | Core returns from the current handler |
| preempt | output | 1 | A strictly more urgent request is waiting |
| exc_num | output | EW | Exception number of the current winner |
| act_rank | output | RW | Rank of the active handler, 6 when idle |

## Verification
A pending bit can be cleared and set in the same cycle. This happens when the core acknowledges a line while a fresh rising edge arrives on that same line. The bench raises `irq_in` in the very cycle that `entry_ack` is driven. After the edge it expects the handler's rank to be pushed and the line's pending bit to read back as still set, following R10. A second case pairs a word-1 set write with the acknowledge of a different handler's line and checks that both effects land.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int EXC_NMI        = 2;
  localparam int EXC_FAULT      = 3;
  localparam int EXC_IRQ_BASE   = 16;
  localparam int RANK_NMI       = 0;
  localparam int RANK_FAULT     = 1;
  localparam int RANK_PROG_BASE = 2;
  localparam int REG_ENABLE     = 0;
  localparam int REG_PEND_SET   = 1;
  localparam int REG_PEND_CLR   = 2;
  localparam int REG_PRIO_BASE  = 3;

  // register word holding the priority byte of a line
  function automatic int prio_word(input int line);
    return REG_PRIO_BASE + line / 4;
  endfunction

  // lowest stored bit of a line's priority byte
  function automatic int prio_lsb(input int line, input int pbits);
    return 8 * (line % 4) + 8 - pbits;
  endfunction

  // bits of a priority word that are never stored
  function automatic logic [31:0] unstored_mask(input int pbits);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8 - pbits; k++)
        m[8*b+k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_nest_regs.sv
module irq_nest_regs
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PB      = 2,
  parameter int AW      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_IRQ-1:0]           irq_in,
  input  logic                         nmi_in,
  input  logic                         fault_in,
  input  logic                         reg_we,
  input  logic [AW-1:0]                reg_addr,
  input  logic [31:0]                  reg_wdata,
  input  logic [NUM_IRQ-1:0]           ack_irq,
  input  logic                         ack_nmi,
  input  logic                         ack_fault,
  output logic [NUM_IRQ-1:0]           en_q,
  output logic [NUM_IRQ-1:0]           pend_q,
  output logic [NUM_IRQ-1:0][PB-1:0]   prio_q,
  output logic                         nmi_pend,
  output logic                         fault_pend,
  output logic [31:0]                  reg_rdata
);
  logic [NUM_IRQ-1:0] irq_d;
  logic               nmi_d, fault_d;
  logic [NUM_IRQ-1:0] irq_edge, set_reg, clr_reg;
  logic               wr_en, wr_pset, wr_pclr;

  assign irq_edge = irq_in & ~irq_d;
  assign wr_en    = reg_we && (reg_addr == AW'(REG_ENABLE));
  assign wr_pset  = reg_we && (reg_addr == AW'(REG_PEND_SET));
  assign wr_pclr  = reg_we && (reg_addr == AW'(REG_PEND_CLR));
  assign set_reg  = wr_pset ? reg_wdata[NUM_IRQ-1:0] : '0;
  assign clr_reg  = wr_pclr ? reg_wdata[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_d      <= '0;
      nmi_d      <= 1'b0;
      fault_d    <= 1'b0;
      en_q       <= '0;
      pend_q     <= '0;
      nmi_pend   <= 1'b0;
      fault_pend <= 1'b0;
    end else begin
      irq_d   <= irq_in;
      nmi_d   <= nmi_in;
      fault_d <= fault_in;
      if (wr_en) en_q <= reg_wdata[NUM_IRQ-1:0];
      // sets are applied last so they win over clears
      pend_q     <= (pend_q & ~clr_reg & ~ack_irq) | set_reg | irq_edge;
      nmi_pend   <= (nmi_pend & ~ack_nmi) | (nmi_in & ~nmi_d);
      fault_pend <= (fault_pend & ~ack_fault) | (fault_in & ~fault_d);
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    localparam int WORD = prio_word(g);
    localparam int LSB  = prio_lsb(g, PB);
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_q[g] <= '0;
      else if (reg_we && (reg_addr == AW'(WORD)))
        prio_q[g] <= reg_wdata[LSB +: PB];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(REG_ENABLE))
      reg_rdata[NUM_IRQ-1:0] = en_q;
    else if (reg_addr == AW'(REG_PEND_SET) || reg_addr == AW'(REG_PEND_CLR))
      reg_rdata[NUM_IRQ-1:0] = pend_q;
    for (int i = 0; i < NUM_IRQ; i++)
      if (reg_addr == AW'(prio_word(i)))
        reg_rdata[prio_lsb(i, PB) +: PB] = prio_q[i];
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PB      = 2,
  parameter int RW      = 3,
  parameter int EW      = 6,
  parameter int IDLE    = 6
) (
  input  logic [NUM_IRQ-1:0]         cand,
  input  logic [NUM_IRQ-1:0][PB-1:0] prio,
  input  logic                       nmi_pend,
  input  logic                       fault_pend,
  output logic                       win_valid,
  output logic [RW-1:0]              win_rank,
  output logic [EW-1:0]              win_exc,
  output logic [NUM_IRQ-1:0]         win_sel,
  output logic                       win_nmi,
  output logic                       win_fault
);
  function automatic logic [RW-1:0] line_rank(input logic [PB-1:0] p);
    return RW'(p) + RW'(RANK_PROG_BASE);
  endfunction

  always_comb begin
    win_valid = 1'b0;
    win_rank  = RW'(IDLE);
    win_exc   = '0;
    win_sel   = '0;
    win_nmi   = 1'b0;
    win_fault = 1'b0;
    // ascending scan with strict compare keeps the lowest line on ties
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!win_valid || line_rank(prio[i]) < win_rank)) begin
        win_valid = 1'b1;
        win_rank  = line_rank(prio[i]);
        win_exc   = EW'(EXC_IRQ_BASE + i);
        win_sel   = '0;
        win_sel[i] = 1'b1;
      end
    end
    if (nmi_pend) begin
      win_valid = 1'b1;
      win_rank  = RW'(RANK_NMI);
      win_exc   = EW'(EXC_NMI);
      win_sel   = '0;
      win_nmi   = 1'b1;
    end else if (fault_pend) begin
      win_valid = 1'b1;
      win_rank  = RW'(RANK_FAULT);
      win_exc   = EW'(EXC_FAULT);
      win_sel   = '0;
      win_fault = 1'b1;
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH = 6,
  parameter int RW    = 3,
  parameter int IDLE  = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [RW-1:0] push_rank,
  input  logic          pop,
  output logic [RW-1:0] top_rank,
  output logic [CW-1:0] depth
);
  logic [DEPTH-1:0][RW-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      depth <= '0;
    end else if (push && depth < CW'(DEPTH)) begin
      lvl_q[depth] <= push_rank;
      depth        <= depth + 1'b1;
    end else if (pop && depth != '0) begin
      depth <= depth - 1'b1;
    end
  end

  assign top_rank = (depth == '0) ? RW'(IDLE) : lvl_q[depth - 1'b1];
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PB      = 2,
  parameter int AW      = $clog2(REG_PRIO_BASE + (NUM_IRQ + 3) / 4),
  parameter int EW      = $clog2(EXC_IRQ_BASE + NUM_IRQ),
  parameter int RW      = $clog2((1 << PB) + RANK_PROG_BASE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  input  logic               fault_in,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               entry_ack,
  input  logic               exit_ack,
  output logic               preempt,
  output logic [EW-1:0]      exc_num,
  output logic [RW-1:0]      act_rank
);
  localparam int IDLE  = (1 << PB) + RANK_PROG_BASE;
  localparam int DEPTH = IDLE;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [NUM_IRQ-1:0]         en_q, pend_q, win_sel;
  logic [NUM_IRQ-1:0][PB-1:0] prio_q;
  logic                       nmi_pend, fault_pend;
  logic                       win_valid, win_nmi, win_fault;
  logic [RW-1:0]              win_rank;
  logic [CW-1:0]              depth;
  logic                       ack_fire, pop_fire;

  assign ack_fire = entry_ack && preempt;
  assign pop_fire = exit_ack && !ack_fire && depth != '0;

  irq_nest_regs #(.NUM_IRQ(NUM_IRQ), .PB(PB), .AW(AW)) u_regs (
    .clk, .rst_n, .irq_in, .nmi_in, .fault_in,
    .reg_we, .reg_addr, .reg_wdata,
    .ack_irq  (ack_fire ? win_sel : '0),
    .ack_nmi  (ack_fire && win_nmi),
    .ack_fault(ack_fire && win_fault),
    .en_q, .pend_q, .prio_q, .nmi_pend, .fault_pend, .reg_rdata
  );

  irq_nest_arb #(.NUM_IRQ(NUM_IRQ), .PB(PB), .RW(RW), .EW(EW), .IDLE(IDLE)) u_arb (
    .cand(en_q & pend_q), .prio(prio_q), .nmi_pend, .fault_pend,
    .win_valid, .win_rank, .win_exc(exc_num), .win_sel, .win_nmi, .win_fault
  );

  irq_nest_stack #(.DEPTH(DEPTH), .RW(RW), .IDLE(IDLE)) u_stack (
    .clk, .rst_n, .push(ack_fire), .push_rank(win_rank), .pop(pop_fire),
    .top_rank(act_rank), .depth
  );

  assign preempt = win_valid && (win_rank < act_rank);
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
  import irq_nest_pkg::*;
#(
  parameter int PB   = 2,
  parameter int AW   = 4,
  parameter int EW   = 6,
  parameter int RW   = 3,
  parameter int CW   = 3,
  parameter int IDLE = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          entry_ack,
  input logic          exit_ack,
  input logic          ack_fire,
  input logic          nmi_pend,
  input logic [EW-1:0] exc_num,
  input logic [RW-1:0] win_rank,
  input logic [RW-1:0] act_rank,
  input logic [CW-1:0] depth,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_rdata
);
  localparam logic [31:0] LOW = unstored_mask(PB);

  a_r6_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> exc_num == EW'(EXC_NMI));

  a_r8_entry_push: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> act_rank == $past(win_rank));

  a_r7_nest_deeper: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> act_rank < $past(act_rank));

  a_r9_exit_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_ack && !ack_fire && depth != '0) |=> depth == $past(depth) - 1'b1);

  a_r9_empty_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_ack && !entry_ack && depth == '0) |=> act_rank == RW'(IDLE));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(IDLE));

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr >= AW'(REG_PRIO_BASE) |-> (reg_rdata & LOW) == '0);
endmodule

bind irq_nest_ctrl irq_nest_chk #(
  .PB(PB), .AW(AW), .EW(EW), .RW(RW), .CW(CW), .IDLE(IDLE)
) u_chk (
  .clk, .rst_n, .entry_ack, .exit_ack, .ack_fire, .nmi_pend,
  .exc_num, .win_rank, .act_rank, .depth, .reg_addr, .reg_rdata
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  localparam int N = 32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        nmi_in = 1'b0, fault_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        entry_ack = 1'b0, exit_ack = 1'b0;
  logic        preempt;
  logic [5:0]  exc_num;
  logic [2:0]  act_rank;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_nest_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; step(); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic enter(); entry_ack = 1'b1; step(); entry_ack = 1'b0; #1; endtask
  task automatic leave(); exit_ack = 1'b1; step(); exit_ack = 1'b0; #1; endtask

  task automatic clean();
    irq_in = '0; nmi_in = 1'b0; fault_in = 1'b0;
    wr(4'd0, 32'h0); wr(4'd2, 32'hFFFF_FFFF);
    for (int k = 0; k < 7; k++) leave();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1;
    chk("R1 preempt", preempt, 0);
    chk("R1 act_rank", act_rank, 6);
    rd(4'd0, d); chk("R1 enable", d, 0);
    rd(4'd1, d); chk("R1 pending", d, 0);
    rd(4'd3, d); chk("R1 prio", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, d); chk("R2 all ones", d, 32'hC0C0_C0C0);
    wr(4'd4, 32'h1234_5678); rd(4'd4, d); chk("R2 mixed", d, 32'h0000_4040);
    wr(4'd3, 0); wr(4'd4, 0);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    irq_in[5] = 1'b1; step(); rd(4'd1, d);
    chk("R3 edge sets", d, 32'h20);
    chk("R4 disabled waits", preempt, 0);
    wr(4'd0, 32'h20); rd(4'd0, d); chk("R3 enable rd", d, 32'h20);
    chk("R4 enabled preempt", preempt, 1);
    chk("R5 exc line5", exc_num, 21);
    wr(4'd2, 32'h20); step(); rd(4'd1, d);
    chk("R3 level no reset", d, 0);
    chk("R3 clear drops", preempt, 0);
    wr(4'd1, 32'h80); rd(4'd2, d); chk("R3 write set", d, 32'h80);
    chk("R4 line7 masked", preempt, 0);
    clean();
  endtask

  task automatic t_arb_nest();
    logic [31:0] d;
    wr(4'd3, 32'h8000_0000); wr(4'd5, 32'h0040_4000);
    wr(4'd1, 32'h608); wr(4'd0, 32'h608); #1;
    chk("R5 lower value wins", exc_num, 25);
    enter();
    chk("R8 act level1", act_rank, 3);
    rd(4'd1, d); chk("R8 pend cleared", d, 32'h408);
    chk("R5 tie lower number", exc_num, 26);
    chk("R7 equal waits", preempt, 0);
    leave();
    chk("R9 pop idle", act_rank, 6);
    chk("R7 after exit", preempt, 1);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd1, 32'h8); #1; chk("R5 line3", exc_num, 19);
    enter(); chk("R8 act level2", act_rank, 4);
    wr(4'd1, 32'h200); #1; chk("R7 more urgent", preempt, 1);
    enter(); chk("R8 nested", act_rank, 3);
    nmi_in = 1'b1; step(); #1;
    chk("R6 nmi exc", exc_num, 2); chk("R6 nmi preempts", preempt, 1);
    enter(); chk("R6 nmi rank", act_rank, 0);
    leave(); chk("R9 restore 3", act_rank, 3);
    leave(); chk("R9 restore 4", act_rank, 4);
    leave(); chk("R9 idle", act_rank, 6);
    leave(); chk("R9 empty exit", act_rank, 6);
    clean();
  endtask

  task automatic t_fixed();
    wr(4'd1, 32'h1); wr(4'd0, 32'h1);
    nmi_in = 1'b1; fault_in = 1'b1; step(); #1;
    chk("R6 nmi over fault", exc_num, 2);
    enter(); chk("R6 fault waits", preempt, 0);
    chk("R6 fault next", exc_num, 3);
    leave(); chk("R6 fault over line", exc_num, 3);
    enter(); chk("R6 fault rank", act_rank, 1);
    entry_ack = 1'b1; step(); entry_ack = 1'b0; #1;
    chk("R8 ack ignored", act_rank, 1);
    leave();
    clean();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(4'd6, 32'h0); wr(4'd1, 32'h1000); wr(4'd0, 32'h1000); #1;
    chk("R10 pre exc", exc_num, 28);
    irq_in[12] = 1'b1; entry_ack = 1'b1; step(); entry_ack = 1'b0; #1;
    chk("R10 pushed", act_rank, 2);
    rd(4'd1, d); chk("R10 edge beats ack", d, 32'h1000);
    wr(4'd2, 32'h1000);
    wr(4'd1, 32'h2); wr(4'd0, 32'h1002); #1;
    chk("R10 line1 ready", exc_num, 17);
    leave(); #1;
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h1000;
    entry_ack = 1'b1; step(); entry_ack = 1'b0; reg_we = 1'b0;
    rd(4'd1, d); chk("R10 set with other ack", d, 32'h1000);
    chk("R10 ack landed", act_rank, 2);
    clean();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_prio();
    t_pend();
    t_arb_nest();
    t_fixed();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule